// File: doc/BRIEF.md
# Per-Pin Edge Interrupt Qualifier

This block sits next to a GPIO bank whose own interrupt logic can only say that some pin in a 32-pin bank changed level. It resolves that coarse indication into per-pin rising and falling events. It keeps a snapshot of the pin levels taken at the last evaluation. On every sample strobe it compares the live pins against that snapshot. The differences are filtered through a per-pin enable and per-pin rising and falling selects, and the result is presented as a one-cycle event vector together with an any-event flag.

Configuration arrives as single-pin writes. A mode write selects rising only, falling only or both edges for one pin, and any other code is refused with a one-cycle reject pulse. An enable write masks or unmasks one pin. When the first pin of an idle bank is unmasked, that bank's snapshot is reloaded from the live pins and its pending-change flag is dropped, so history gathered while the bank was idle cannot produce a false edge. The block also keeps the per-bank change enable and the pending-change flag that the bank-level detector would hold. `NUM_PINS` must be a whole multiple of `BANK_W`.

Top module: `pin_edge_qualifier`

## Requirements
- R1: After reset, `event_o`, `any_event_o`, `mode_reject_o`, `bank_en_o` and `bank_pend_o` are all zero, and every enable, edge select and snapshot bit is zero.
- R2: A sample strobe reports a rising event for a pin when its snapshot bit is 0, its live bit is 1, the pin is enabled and its rising select is set.
- R3: A sample strobe reports a falling event for a pin when its snapshot bit is 1, its live bit is 0, the pin is enabled and its falling select is set.
- R4: A pin whose mode sets both selects reports both polarities of change.
- R5: Every sample strobe copies the live levels of all pins into the snapshot, disabled pins included.
- R6: `event_o` is the OR of the rising and falling results. It is driven in the cycle after the sample edge only and is zero in every other cycle. `any_event_o` is high exactly when `event_o` is non-zero.
- R7: Mode codes are 3'b001 for rising, 3'b010 for falling and 3'b011 for both. Any other code, including the level codes 3'b100 and 3'b101, leaves the pin's selects unchanged and raises `mode_reject_o` for the one cycle after the write.
- R8: Unmasking a pin whose bank has no pin enabled reloads that bank's snapshot from the live pins and clears the bank's pending flag in the same edge, and `bank_en_o` for the bank goes high.
- R9: `bank_en_o[b]` goes low only when the last enabled pin of bank b is masked, and it goes high only through an unmask write.
- R10: `bank_pend_o[b]` is set when any pin of bank b differs from its value in the previous cycle while the bank is enabled. It is cleared by a sample strobe, and the clear wins over a new change in the same edge. Masking a bank does not clear it.
- R11: A pin that is disabled at the sample edge produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_PINS | Live pin levels |
| sample_i | input | 1 | Evaluate edges and refresh the snapshot |
| mode_we_i | input | 1 | Mode write strobe |
| mode_pin_i | input | PIN_IW | Pin targeted by the mode write |
| mode_code_i | input | 3 | Requested edge mode |
| en_we_i | input | 1 | Enable write strobe |
| en_val_i | input | 1 | 1 unmasks, 0 masks |
| en_pin_i | input | PIN_IW | Pin targeted by the enable write |
| event_o | output | NUM_PINS | Qualified edge events, one cycle |
| any_event_o | output | 1 | High when any event bit is set |
| mode_reject_o | output | 1 | One-cycle pulse on a refused mode code |
| bank_en_o | output | NUM_BANKS | Bank has at least one enabled pin |
| bank_pend_o | output | NUM_BANKS | Bank saw a change since the last sample |

## Verification
The bound checker watches the following on every cycle: events appear only right after a sample and only on pins that were enabled at that edge; the any-event flag tracks the vector; the reject pulse has exactly the refused-write cause; a sample empties every pending flag; and a bank only turns on through an unmask, with its pending flag clear. Edge polarity per mode, snapshot refresh on disabled pins and the anti-false-edge reload depend on a history of pin levels. Only the bench's scenarios can show these, through sequences that would produce a wrong event if the snapshot were stale.

// File: rtl/edgeq_pkg.sv
package edgeq_pkg;

  typedef enum logic [2:0] {
    EM_NONE    = 3'b000,
    EM_RISE    = 3'b001,
    EM_FALL    = 3'b010,
    EM_BOTH    = 3'b011,
    EM_LVL_HI  = 3'b100,
    EM_LVL_LO  = 3'b101
  } edge_mode_e;

  // Only pure edge modes are accepted.
  function automatic logic mode_ok(input logic [2:0] code);
    return (code == EM_RISE) || (code == EM_FALL) || (code == EM_BOTH);
  endfunction

  function automatic logic rise_hit(input logic snap, input logic cur,
                                    input logic en, input logic sel);
    return !snap && cur && en && sel;
  endfunction

  function automatic logic fall_hit(input logic snap, input logic cur,
                                    input logic en, input logic sel);
    return snap && !cur && en && sel;
  endfunction

endpackage

// File: rtl/edgeq_cfg.sv
module edgeq_cfg #(
  parameter int NUM_PINS = 64,
  parameter int BANK_W   = 32,
  localparam int NUM_BANKS = NUM_PINS / BANK_W,
  localparam int PIN_IW    = $clog2(NUM_PINS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_we,
  input  logic [PIN_IW-1:0]    mode_pin,
  input  logic [2:0]           mode_code,
  input  logic                 en_we,
  input  logic                 en_val,
  input  logic [PIN_IW-1:0]    en_pin,
  output logic [NUM_PINS-1:0]  pin_en,
  output logic [NUM_PINS-1:0]  rise_sel,
  output logic [NUM_PINS-1:0]  fall_sel,
  output logic [NUM_BANKS-1:0] bank_en,
  output logic [NUM_BANKS-1:0] reload,
  output logic                 reject
);
  import edgeq_pkg::*;

  logic [NUM_PINS-1:0] en_q, rise_q, fall_q;
  logic                rej_q;
  int                  en_bank;

  always_comb en_bank = int'(en_pin) / BANK_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      rise_q <= '0;
      fall_q <= '0;
      rej_q  <= 1'b0;
    end else begin
      rej_q <= mode_we && !mode_ok(mode_code);
      if (mode_we && mode_ok(mode_code)) begin
        rise_q[mode_pin] <= mode_code[0];
        fall_q[mode_pin] <= mode_code[1];
      end
      if (en_we) en_q[en_pin] <= en_val;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_en[b] = |en_q[b*BANK_W +: BANK_W];
    // Unmask into an idle bank triggers a snapshot reload.
    assign reload[b]  = en_we && en_val && (en_bank == b) && !bank_en[b];
  end

  assign pin_en   = en_q;
  assign rise_sel = rise_q;
  assign fall_sel = fall_q;
  assign reject   = rej_q;

endmodule

// File: rtl/edgeq_bank_mon.sv
module edgeq_bank_mon #(
  parameter int NUM_PINS = 64,
  parameter int BANK_W   = 32,
  localparam int NUM_BANKS = NUM_PINS / BANK_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PINS-1:0]  pins,
  input  logic                 clr_all,
  input  logic [NUM_BANKS-1:0] reload,
  input  logic [NUM_BANKS-1:0] bank_en,
  output logic [NUM_BANKS-1:0] pend
);
  logic [NUM_PINS-1:0]  prev_q;
  logic [NUM_BANKS-1:0] pend_q;
  logic [NUM_BANKS-1:0] chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pins;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign chg[b] = |(pins[b*BANK_W +: BANK_W] ^ prev_q[b*BANK_W +: BANK_W]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     pend_q[b] <= 1'b0;
      else if (clr_all || reload[b])  pend_q[b] <= 1'b0;
      else if (bank_en[b] && chg[b])  pend_q[b] <= 1'b1;
    end
  end

  assign pend = pend_q;

endmodule

// File: rtl/edgeq_eval.sv
module edgeq_eval #(
  parameter int NUM_PINS = 64,
  parameter int BANK_W   = 32,
  localparam int NUM_BANKS = NUM_PINS / BANK_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PINS-1:0]  pins,
  input  logic                 sample,
  input  logic [NUM_BANKS-1:0] reload,
  input  logic [NUM_PINS-1:0]  pin_en,
  input  logic [NUM_PINS-1:0]  rise_sel,
  input  logic [NUM_PINS-1:0]  fall_sel,
  output logic [NUM_PINS-1:0]  events,
  output logic                 any_evt
);
  import edgeq_pkg::*;

  logic [NUM_PINS-1:0] snap_q;
  logic [NUM_PINS-1:0] rise_w, fall_w;
  logic [NUM_PINS-1:0] evt_q;
  logic                any_q;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign rise_w[i] = rise_hit(snap_q[i], pins[i], pin_en[i], rise_sel[i]);
    assign fall_w[i] = fall_hit(snap_q[i], pins[i], pin_en[i], fall_sel[i]);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_snap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        snap_q[b*BANK_W +: BANK_W] <= '0;
      else if (sample || reload[b])
        snap_q[b*BANK_W +: BANK_W] <= pins[b*BANK_W +: BANK_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
      any_q <= 1'b0;
    end else begin
      evt_q <= sample ? (rise_w | fall_w) : '0;
      any_q <= sample && ((|rise_w) || (|fall_w));
    end
  end

  assign events  = evt_q;
  assign any_evt = any_q;

endmodule

// File: rtl/pin_edge_qualifier.sv
module pin_edge_qualifier #(
  parameter int NUM_PINS = 64,
  parameter int BANK_W   = 32,
  localparam int NUM_BANKS = NUM_PINS / BANK_W,
  localparam int PIN_IW    = $clog2(NUM_PINS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PINS-1:0]  pins_i,
  input  logic                 sample_i,
  input  logic                 mode_we_i,
  input  logic [PIN_IW-1:0]    mode_pin_i,
  input  logic [2:0]           mode_code_i,
  input  logic                 en_we_i,
  input  logic                 en_val_i,
  input  logic [PIN_IW-1:0]    en_pin_i,
  output logic [NUM_PINS-1:0]  event_o,
  output logic                 any_event_o,
  output logic                 mode_reject_o,
  output logic [NUM_BANKS-1:0] bank_en_o,
  output logic [NUM_BANKS-1:0] bank_pend_o
);
  logic [NUM_PINS-1:0]  pin_en_w, rise_sel_w, fall_sel_w;
  logic [NUM_BANKS-1:0] bank_en_w, reload_w;

  edgeq_cfg #(.NUM_PINS(NUM_PINS), .BANK_W(BANK_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .mode_we(mode_we_i), .mode_pin(mode_pin_i), .mode_code(mode_code_i),
    .en_we(en_we_i), .en_val(en_val_i), .en_pin(en_pin_i),
    .pin_en(pin_en_w), .rise_sel(rise_sel_w), .fall_sel(fall_sel_w),
    .bank_en(bank_en_w), .reload(reload_w), .reject(mode_reject_o)
  );

  edgeq_bank_mon #(.NUM_PINS(NUM_PINS), .BANK_W(BANK_W)) u_mon (
    .clk(clk), .rst_n(rst_n), .pins(pins_i), .clr_all(sample_i),
    .reload(reload_w), .bank_en(bank_en_w), .pend(bank_pend_o)
  );

  edgeq_eval #(.NUM_PINS(NUM_PINS), .BANK_W(BANK_W)) u_eval (
    .clk(clk), .rst_n(rst_n), .pins(pins_i), .sample(sample_i),
    .reload(reload_w), .pin_en(pin_en_w), .rise_sel(rise_sel_w),
    .fall_sel(fall_sel_w), .events(event_o), .any_evt(any_event_o)
  );

  assign bank_en_o = bank_en_w;

endmodule

// File: rtl/pin_edge_qualifier_chk.sv
module pin_edge_qualifier_chk #(
  parameter int NUM_PINS = 64,
  parameter int BANK_W   = 32,
  localparam int NUM_BANKS = NUM_PINS / BANK_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sample_i,
  input logic                 mode_we_i,
  input logic [2:0]           mode_code_i,
  input logic                 en_we_i,
  input logic                 en_val_i,
  input logic [NUM_PINS-1:0]  event_o,
  input logic                 any_event_o,
  input logic                 mode_reject_o,
  input logic [NUM_BANKS-1:0] bank_en_o,
  input logic [NUM_BANKS-1:0] bank_pend_o,
  input logic [NUM_PINS-1:0]  pin_en
);
  import edgeq_pkg::*;

  AST_EVENT_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (event_o != '0) |-> $past(sample_i)); // R6
  AST_ANY_TRACKS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    any_event_o == (event_o != '0)); // R6
  AST_EVENT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (event_o & ~$past(pin_en)) == '0); // R11
  AST_REJECT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_reject_o |-> ($past(mode_we_i) && !mode_ok($past(mode_code_i)))); // R7
  AST_REJECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_we_i) && !mode_ok($past(mode_code_i))) |-> mode_reject_o); // R7
  AST_SAMPLE_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sample_i) |-> (bank_pend_o == '0)); // R10

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    AST_BANK_ON_BY_UNMASK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bank_en_o[b]) |-> $past(en_we_i && en_val_i)); // R9
    AST_RELOAD_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bank_en_o[b]) |-> !bank_pend_o[b]); // R8
  end

endmodule

bind pin_edge_qualifier pin_edge_qualifier_chk #(.NUM_PINS(NUM_PINS), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .mode_we_i(mode_we_i),
  .mode_code_i(mode_code_i), .en_we_i(en_we_i), .en_val_i(en_val_i),
  .event_o(event_o), .any_event_o(any_event_o), .mode_reject_o(mode_reject_o),
  .bank_en_o(bank_en_o), .bank_pend_o(bank_pend_o), .pin_en(pin_en_w)
);

// File: tb/tb_pin_edge_qualifier.sv
`timescale 1ns/1ps
module tb_pin_edge_qualifier;
  localparam int NP = 64;
  localparam int NB = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins_i = '0;
  logic          sample_i = 1'b0;
  logic          mode_we_i = 1'b0;
  logic [5:0]    mode_pin_i = '0;
  logic [2:0]    mode_code_i = '0;
  logic          en_we_i = 1'b0;
  logic          en_val_i = 1'b0;
  logic [5:0]    en_pin_i = '0;
  logic [NP-1:0] event_o;
  logic          any_event_o, mode_reject_o;
  logic [NB-1:0] bank_en_o, bank_pend_o;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  pin_edge_qualifier dut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .sample_i(sample_i),
    .mode_we_i(mode_we_i), .mode_pin_i(mode_pin_i), .mode_code_i(mode_code_i),
    .en_we_i(en_we_i), .en_val_i(en_val_i), .en_pin_i(en_pin_i),
    .event_o(event_o), .any_event_o(any_event_o), .mode_reject_o(mode_reject_o),
    .bank_en_o(bank_en_o), .bank_pend_o(bank_pend_o)
  );

  // Compact pin pattern: bits 3..0 -> pins 3..0, bit 4 -> pin 33, bit 5 -> pin 34.
  function automatic logic [NP-1:0] spread(input logic [5:0] c);
    logic [NP-1:0] v = '0;
    v[3:0] = c[3:0];
    v[33]  = c[4];
    v[34]  = c[5];
    return v;
  endfunction

  // {live pins, expected events} after setup: pin0 rise, pin1 fall, pin2 both,
  // pin3 rise but disabled, pin33 both, pin34 rise.
  localparam logic [11:0] TBL [8] = '{
    {6'b000001, 6'b000001},
    {6'b000110, 6'b000100},
    {6'b001100, 6'b000010},
    {6'b110000, 6'b110100},
    {6'b100011, 6'b010001},
    {6'b000011, 6'b000000},
    {6'b111111, 6'b110100},
    {6'b000000, 6'b010110}
  };

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_mode(input int pin, input logic [2:0] code);
    mode_we_i = 1'b1; mode_pin_i = 6'(pin); mode_code_i = code;
    step();
    mode_we_i = 1'b0;
  endtask

  task automatic set_en(input int pin, input logic val);
    en_we_i = 1'b1; en_pin_i = 6'(pin); en_val_i = val;
    step();
    en_we_i = 1'b0;
  endtask

  task automatic do_sample();
    sample_i = 1'b1;
    step();
    sample_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) step();
    chk("R1 event", event_o, '0);
    chk("R1 flags", {61'd0, any_event_o, mode_reject_o}, '0);
    chk("R1 bank", {60'd0, bank_en_o, bank_pend_o}, '0);
    rst_n = 1'b1;
    step();
    chk("R1 after release", {59'd0, any_event_o, bank_en_o, bank_pend_o}, '0);

    set_mode(0, 3'b001); set_mode(1, 3'b010); set_mode(2, 3'b011);
    set_mode(3, 3'b001); set_mode(33, 3'b011); set_mode(34, 3'b001);
    set_en(0, 1'b1);
    chk("R8 bank0 on", {62'd0, bank_en_o}, 64'h1);
    set_en(1, 1'b1); set_en(2, 1'b1); set_en(33, 1'b1); set_en(34, 1'b1);
    chk("R8 both banks on", {62'd0, bank_en_o}, 64'h3);

    // R2 R3 R4 R11: table walk
    for (int i = 0; i < 8; i++) begin
      pins_i = spread(TBL[i][11:6]);
      do_sample();
      chk($sformatf("R2/R3/R4 row %0d", i), event_o, spread(TBL[i][5:0]));
      chk($sformatf("R6 any row %0d", i), {63'd0, any_event_o}, {63'd0, TBL[i][5:0] != 6'd0});
    end
    step();
    chk("R6 event cleared", event_o, '0);

    // R7: refused level mode keeps rise-only on pin0
    mode_we_i = 1'b1; mode_pin_i = 6'd0; mode_code_i = 3'b100;
    step();
    mode_we_i = 1'b0;
    chk("R7 reject pulse", {63'd0, mode_reject_o}, 64'h1);
    step();
    chk("R7 reject one cycle", {63'd0, mode_reject_o}, '0);
    pins_i[0] = 1'b1; do_sample();
    chk("R7 rise kept", event_o, 64'h1);
    step();
    chk("R6 single cycle", event_o, '0);
    pins_i[0] = 1'b0; do_sample();
    chk("R7 no fall", event_o, '0);
    set_mode(0, 3'b010);
    chk("R7 valid no reject", {63'd0, mode_reject_o}, '0);
    pins_i[0] = 1'b1; do_sample();
    chk("R7 fall mode no rise", event_o, '0);
    pins_i[0] = 1'b0; do_sample();
    chk("R7 fall mode fall", event_o, 64'h1);

    // R5 R11: disabled pin3 still refreshes its snapshot
    pins_i[3] = 1'b1; do_sample();
    chk("R11 disabled pin", event_o, '0);
    set_en(3, 1'b1);
    do_sample();
    chk("R5 snapshot refreshed", event_o, '0);
    pins_i[3] = 1'b0; do_sample();
    pins_i[3] = 1'b1; do_sample();
    chk("R2 pin3 now enabled", event_o, 64'h8);

    // R9 R10 R8: bank 1 bookkeeping
    set_en(34, 1'b0);
    chk("R9 bank1 stays on", {62'd0, bank_en_o}, 64'h3);
    pins_i[35] = 1'b1; step();
    chk("R10 pend set", {62'd0, bank_pend_o}, 64'h2);
    set_en(33, 1'b0);
    chk("R9 bank1 off", {62'd0, bank_en_o}, 64'h1);
    chk("R10 mask keeps pend", {62'd0, bank_pend_o}, 64'h2);
    pins_i[33] = 1'b1; step();
    set_en(33, 1'b1);
    chk("R8 reload clears pend", {62'd0, bank_pend_o}, '0);
    chk("R8 bank1 on again", {62'd0, bank_en_o}, 64'h3);
    do_sample();
    chk("R8 no false edge", event_o, '0);
    pins_i[35] = 1'b0; step();
    chk("R10 pend again", {62'd0, bank_pend_o}, 64'h2);
    do_sample();
    chk("R10 sample clears", {62'd0, bank_pend_o}, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule